// File: doc/BRIEF.md
# DRAM Bank Index Hashing Unit

This block sits between the address decoder and the DRAM command scheduler. Each request carries a row address, a raw bank field and an opaque tag. The block replaces the bank field with a hashed bank number, so that address patterns that would otherwise pile onto one bank are spread across all of them. The mapping is chosen at run time by a 2-bit mode input, which is sampled together with each accepted request.

There are three mappings. Pass-through leaves the bank field as it is. XOR folds the low row bits into the bank field. Polynomial mode applies a fixed XOR matrix over row bits 0 to 12, which gives a pseudo-random spread. Polynomial mode is only defined for a 16-bank part. If it is requested with any other bank count, the bank field is forwarded unchanged and a sticky configuration error flag is raised.

Both ends use valid/ready. A request is taken when `in_valid` and `in_ready` are both high at a rising clock edge. It appears on the output one cycle later. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds all of its fields, and new requests are refused.

Top module: `bank_hash_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `cfg_err` are 0 and `in_ready` is 1.
- R2: With mode 0, `out_bank` equals the request's bank field.
- R3: Mode 3 is reserved and maps exactly like mode 0.
- R4: With mode 1, `out_bank` is the bank field XOR the low log2(BANKS) row bits.
- R5: With mode 2 and BANKS = 16, each output bit is the matching bank bit XOR a set of row bits:
  - bit 0 uses rows {0,3,4,6,8,9,10,11};
  - bit 1 uses rows {0,1,3,5,6,7,8,12};
  - bit 2 uses rows {1,2,4,6,7,8,9};
  - bit 3 uses rows {2,3,5,7,8,9,10}.
- R6: With mode 2 and BANKS ≠ 16, the bank field is forwarded unchanged. `cfg_err` goes to 1 in the cycle after acceptance and stays at 1 until reset.
- R7: A request accepted at edge N is shown with `out_valid` = 1 after edge N. Its row, tag and hashed bank appear together, and requests leave in the order they were accepted.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output fields stay stable, `out_valid` stays 1 and `in_ready` is 0. `in_ready` is 1 when the stage is empty or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Mapping select (0 pass, 1 XOR, 2 polynomial, 3 reserved as pass) |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_row | input | ROW_W | Row address of the request |
| in_bank | input | log2(BANKS) | Raw bank field |
| in_tag | input | TAG_W | Request tag carried alongside |
| out_valid | output | 1 | Hashed request present |
| out_ready | input | 1 | Downstream accepts |
| out_row | output | ROW_W | Row address, aligned with out_bank |
| out_bank | output | log2(BANKS) | Hashed bank number |
| out_tag | output | TAG_W | Tag, aligned with out_bank |
| cfg_err | output | 1 | Sticky flag for an unsupported mode/bank-count pairing |

## Verification
Two things can happen in the same cycle: a new request being accepted and the held result being drained. They can also collide with a stall, where a result is held while a request waits at the input. The bench provokes all of these by randomising `in_valid` and `out_ready` independently over every mode. A scoreboard queue of expected hashes is popped only on output handshakes, and each cycle of a stall is checked for stable fields and a low `in_ready`.

// File: rtl/bank_hash_pkg.sv
package bank_hash_pkg;
  typedef enum logic [1:0] {
    MAP_PASS = 2'd0,
    MAP_XOR  = 2'd1,
    MAP_POLY = 2'd2,
    MAP_RSVD = 2'd3
  } map_mode_e;

  localparam int POLY_BANKS  = 16;
  localparam int POLY_BITS   = 4;
  localparam int POLY_ROW_W  = 13;

  // tap masks over row[12:0], one per hashed bank bit
  localparam logic [POLY_ROW_W-1:0] POLY_TAPS [POLY_BITS] = '{
    13'h0F59, 13'h11EB, 13'h03D6, 13'h07AC
  };
endpackage

// File: rtl/bank_xor_fold.sv
module bank_xor_fold #(
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0] row_lo,
  input  logic [BANK_W-1:0] bank,
  output logic [BANK_W-1:0] hashed
);
  assign hashed = bank ^ row_lo;
endmodule

// File: rtl/bank_poly_fold.sv
module bank_poly_fold
  import bank_hash_pkg::*;
#(
  parameter int BANKS  = 16,
  parameter int BANK_W = 4
) (
  input  logic [POLY_ROW_W-1:0] row,
  input  logic [BANK_W-1:0]     bank,
  output logic [BANK_W-1:0]     hashed,
  output logic                  supported
);
  generate
    if (BANKS == POLY_BANKS) begin : g_poly
      for (genvar i = 0; i < POLY_BITS; i++) begin : g_bit
        assign hashed[i] = (^(row & POLY_TAPS[i])) ^ bank[i];
      end
      assign supported = 1'b1;
    end else begin : g_none
      logic unused_row;
      assign unused_row = ^row;
      assign hashed     = bank;
      assign supported  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bank_hash_stage.sv
module bank_hash_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (s_valid && s_ready) begin
      full_q <= 1'b1;
      data_q <= s_data;
    end else if (m_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_hash_unit.sv
module bank_hash_unit
  import bank_hash_pkg::*;
#(
  parameter int BANKS  = 16,
  parameter int ROW_W  = 16,
  parameter int TAG_W  = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_W-1:0]  out_row,
  output logic [BANK_W-1:0] out_bank,
  output logic [TAG_W-1:0]  out_tag,
  output logic              cfg_err
);
  localparam int PAY_W = ROW_W + TAG_W + BANK_W;

  logic [BANK_W-1:0] xor_bank, poly_bank, sel_bank;
  logic              poly_ok, accept, err_q;
  logic [PAY_W-1:0]  pay_in, pay_out;
  map_mode_e         mode_e;

  assign mode_e = map_mode_e'(mode);

  bank_xor_fold #(.BANK_W(BANK_W)) u_xor (
    .row_lo (in_row[BANK_W-1:0]),
    .bank   (in_bank),
    .hashed (xor_bank)
  );

  bank_poly_fold #(.BANKS(BANKS), .BANK_W(BANK_W)) u_poly (
    .row       (in_row[POLY_ROW_W-1:0]),
    .bank      (in_bank),
    .hashed    (poly_bank),
    .supported (poly_ok)
  );

  always_comb begin
    unique case (mode_e)
      MAP_XOR:  sel_bank = xor_bank;
      MAP_POLY: sel_bank = poly_bank;
      default:  sel_bank = in_bank;
    endcase
  end

  assign pay_in = {in_row, in_tag, sel_bank};
  assign accept = in_valid && in_ready;

  bank_hash_stage #(.W(PAY_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign out_row  = pay_out[PAY_W-1 -: ROW_W];
  assign out_tag  = pay_out[BANK_W +: TAG_W];
  assign out_bank = pay_out[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (accept && mode_e == MAP_POLY && !poly_ok)
      err_q <= 1'b1;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/bank_hash_chk.sv
module bank_hash_chk #(
  parameter int BANKS = 16,
  parameter int ROW_W = 16,
  parameter int TAG_W = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ROW_W-1:0]  in_row,
  input logic [BANK_W-1:0] in_bank,
  input logic [TAG_W-1:0]  in_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ROW_W-1:0]  out_row,
  input logic [BANK_W-1:0] out_bank,
  input logic [TAG_W-1:0]  out_tag,
  input logic              cfg_err
);
  logic take;
  assign take = in_valid && in_ready;

  // R2 R3
  pass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (mode == 2'd0 || mode == 2'd3) |=> out_bank == $past(in_bank));

  // R4
  xor_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode == 2'd1 |=> out_bank == ($past(in_bank) ^ $past(in_row[BANK_W-1:0])));

  // R6
  bad_poly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode == 2'd2 && BANKS != 16 |=> cfg_err && out_bank == $past(in_bank));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_row == $past(in_row) && out_tag == $past(in_tag));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_bank) && $stable(out_tag));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind bank_hash_unit bank_hash_chk #(.BANKS(BANKS), .ROW_W(ROW_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
  .in_row(in_row), .in_bank(in_bank), .in_tag(in_tag), .out_valid(out_valid),
  .out_ready(out_ready), .out_row(out_row), .out_bank(out_bank), .out_tag(out_tag),
  .cfg_err(cfg_err)
);

// File: tb/tb_bank_hash_unit.sv
module tb_bank_hash_unit;
  localparam int CLK_P = 10;
  localparam int ROW_W = 16;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // 16-bank instance
  logic [1:0] a_mode = '0;
  logic a_in_valid = 0, a_in_ready, a_out_valid, a_out_ready = 0, a_err;
  logic [ROW_W-1:0] a_in_row = '0, a_out_row;
  logic [3:0] a_in_bank = '0, a_out_bank;
  logic [TAG_W-1:0] a_in_tag = '0, a_out_tag;

  // 8-bank instance
  logic [1:0] b_mode = '0;
  logic b_in_valid = 0, b_in_ready, b_out_valid, b_out_ready = 1, b_err;
  logic [ROW_W-1:0] b_in_row = '0, b_out_row;
  logic [2:0] b_in_bank = '0, b_out_bank;
  logic [TAG_W-1:0] b_in_tag = '0, b_out_tag;

  bank_hash_unit #(.BANKS(16), .ROW_W(ROW_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(a_mode), .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_row(a_in_row), .in_bank(a_in_bank), .in_tag(a_in_tag), .out_valid(a_out_valid),
    .out_ready(a_out_ready), .out_row(a_out_row), .out_bank(a_out_bank), .out_tag(a_out_tag),
    .cfg_err(a_err));

  bank_hash_unit #(.BANKS(8), .ROW_W(ROW_W), .TAG_W(TAG_W)) dut_b8 (
    .clk(clk), .rst_n(rst_n), .mode(b_mode), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_row(b_in_row), .in_bank(b_in_bank), .in_tag(b_in_tag), .out_valid(b_out_valid),
    .out_ready(b_out_ready), .out_row(b_out_row), .out_bank(b_out_bank), .out_tag(b_out_tag),
    .cfg_err(b_err));

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int ref_poly(logic [15:0] r, logic [3:0] b);
    logic [3:0] o;
    o[0] = b[0]^r[0]^r[3]^r[4]^r[6]^r[8]^r[9]^r[10]^r[11];
    o[1] = b[1]^r[0]^r[1]^r[3]^r[5]^r[6]^r[7]^r[8]^r[12];
    o[2] = b[2]^r[1]^r[2]^r[4]^r[6]^r[7]^r[8]^r[9];
    o[3] = b[3]^r[2]^r[3]^r[5]^r[7]^r[8]^r[9]^r[10];
    return int'(o);
  endfunction

  function automatic int ref_bank(int banks, int m, logic [15:0] r, int b);
    case (m)
      1: return b ^ (int'(r) % banks);
      2: return (banks == 16) ? ref_poly(r, b[3:0]) : b;
      default: return b;
    endcase
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  int q_bank[$], q_row[$], q_tag[$], q_mode[$];
  bit held = 0;
  int h_row, h_bank, h_tag;

  task automatic step(bit v, int m, logic [15:0] r, int b, int t, bit rdy);
    @(negedge clk);
    a_in_valid = v; a_mode = m[1:0]; a_in_row = r; a_in_bank = b[3:0];
    a_in_tag = t[7:0]; a_out_ready = rdy;
    #1;
    if (held) begin
      check("R8 held valid", int'(a_out_valid), 1);
      check("R8 held row", int'(a_out_row), h_row);
      check("R8 held bank", int'(a_out_bank), h_bank);
      check("R8 held tag", int'(a_out_tag), h_tag);
    end
    if (a_out_valid && !a_out_ready) check("R8 in_ready low in stall", int'(a_in_ready), 0);
    if (!a_out_valid || a_out_ready) check("R8 in_ready high", int'(a_in_ready), 1);
    if (a_out_valid && a_out_ready) begin
      if (q_bank.size() == 0) check("R7 unexpected output", 1, 0);
      else begin
        int eb = q_bank.pop_front(), er = q_row.pop_front();
        int et = q_tag.pop_front(), em = q_mode.pop_front();
        check(mode_req(em), int'(a_out_bank), eb);
        check("R7 row", int'(a_out_row), er);
        check("R7 tag", int'(a_out_tag), et);
      end
    end
    held = a_out_valid && !a_out_ready;
    h_row = int'(a_out_row); h_bank = int'(a_out_bank); h_tag = int'(a_out_tag);
    if (a_in_valid && a_in_ready) begin
      q_bank.push_back(ref_bank(16, m, r, b));
      q_row.push_back(int'(r)); q_tag.push_back(t); q_mode.push_back(m);
    end
  endtask

  task automatic b_send(int m, logic [15:0] r, int b, int exp_bank, int exp_err, string req);
    @(negedge clk);
    b_in_valid = 1; b_mode = m[1:0]; b_in_row = r; b_in_bank = b[2:0]; b_in_tag = 8'h5A;
    @(negedge clk);
    b_in_valid = 0;
    check({req, " bank"}, int'(b_out_bank), exp_bank);
    check({req, " valid"}, int'(b_out_valid), 1);
    check({req, " err"}, int'(b_err), exp_err);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h0BA5_1C));
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(a_out_valid), 0);
    check("R1 cfg_err in reset", int'(a_err), 0);
    check("R1 in_ready in reset", int'(a_in_ready), 1);
    check("R1 b8 cfg_err in reset", int'(b_err), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(a_out_valid), 0);

    // directed latency: one request, visible exactly one edge later
    a_in_valid = 1; a_mode = 0; a_in_row = 16'hABCD; a_in_bank = 4'd5; a_in_tag = 8'h3C;
    a_out_ready = 1;
    @(negedge clk);
    a_in_valid = 0;
    check("R7 valid after one edge", int'(a_out_valid), 1);
    check("R2 pass bank", int'(a_out_bank), 5);
    check("R7 row aligned", int'(a_out_row), 16'hABCD);
    check("R7 tag aligned", int'(a_out_tag), 8'h3C);
    @(negedge clk);
    check("R7 valid drops when drained", int'(a_out_valid), 0);

    // directed corners
    step(1, 2, 16'h0001, 0, 1, 1);
    step(1, 2, 16'h0000, 0, 2, 1);
    step(1, 2, 16'hFFFF, 15, 3, 1);
    for (int k = 0; k < 13; k++) step(1, 2, 16'(1 << k), 0, 10 + k, 1);
    step(1, 1, 16'hFFFF, 0, 30, 1);
    step(1, 1, 16'h000A, 6, 31, 1);
    step(1, 3, 16'h1234, 9, 32, 1);
    step(1, 3, 16'hFFFF, 15, 33, 0);
    step(1, 0, 16'h0F0F, 4, 34, 0);
    step(1, 1, 16'h00F3, 2, 35, 1);
    step(0, 0, 16'h0, 0, 0, 1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit rd = ($urandom % 10) < 7;
      int m = $urandom % 4;
      step(v, m, 16'($urandom), int'($urandom % 16), int'($urandom % 256), rd);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 0, 0, 1);
    check("R7 all requests delivered", q_bank.size(), 0);
    check("R6 no error on 16 banks", int'(a_err), 0);

    // 8-bank instance: XOR then unsupported polynomial
    b_send(1, 16'h00F5, 2, 2 ^ 5, 0, "R4 b8 xor");
    b_send(0, 16'h0007, 3, 3, 0, "R2 b8 pass");
    b_send(2, 16'h1FFF, 6, 6, 1, "R6 b8 poly forwards");
    b_send(0, 16'h0003, 1, 1, 1, "R6 b8 err sticky");
    b_send(1, 16'h0003, 4, 7, 1, "R6 b8 err stays");
    finish_run();
  end
endmodule